// File: doc/BRIEF.md
# Load-Multiple Burst Splitter

This block sits between a load unit and a level-two memory port. It takes one uncached multi-word load request, made of a start byte address and a word count from 1 to 16, and turns it into a series of bus transactions. Each transaction starts at a word address and carries a length in words. No transaction may reach past the end of the 32-byte (eight-word) aligned region it starts in. A piece of exactly one word goes out as a single-word load. Any longer piece goes out as a burst of 2 to 8 words.

The splitter first fills out the partial region the request starts in. It then emits whole eight-word bursts and ends with whatever words remain. Requests and transactions each use a valid/ready handshake. The splitter takes a new request only when it is idle. It holds each transaction steady until the consumer accepts it. A count of zero, or a count above the maximum, is refused with a one-cycle error pulse and produces no transactions.

The control is a three-state machine. S_IDLE waits for a request. On a legal count it moves to S_ISSUE, and on an illegal count it moves to S_REJECT. S_ISSUE presents one piece at a time and returns to S_IDLE when the last piece is accepted. S_REJECT lasts one cycle, raises the error flag and then falls back to S_IDLE.

Top module: `lm_burst_splitter`

## Requirements
- R1: After reset, and whenever no request is in progress, req_ready is 1 and txn_valid and req_err are 0. While a request is in progress, req_ready is 0 and a request offered then is not taken and does not disturb the current one.
- R2: Byte address bits [1:0] of req_addr are ignored. The word position inside the eight-word region is req_addr bits [4:2].
- R3: The first transaction starts at the word-aligned request address. Its length is the smaller of the count and 8 minus the starting word position.
- R4: No transaction crosses a 32-byte aligned boundary. Its word position plus its length never exceeds 8.
- R5: Every transaction after the first starts at byte offset 0x00 of the next aligned region. A transaction that is neither first nor last is an eight-word burst.
- R6: The last transaction carries the words still owed, and the lengths of all transactions of a request add up to the requested count.
- R7: txn_single is 1 exactly when the length is 1, which marks a single-word load. Otherwise the transaction is a burst of 2 to 8 words.
- R8: While txn_valid is 1 and txn_ready is 0, txn_valid, txn_addr, txn_len, txn_single and txn_last stay unchanged in the next cycle.
- R9: txn_last is 1 only on the final transaction of a request. In the cycle after that transaction is accepted, the splitter is idle again.
- R10: A request with count 0 or count above 16 is taken. In the cycle after it is taken, req_err is 1 for exactly one cycle, txn_valid stays 0, and then the splitter is idle.
- R11: A request whose start address lies on a 32-byte boundary has no partial first piece. It emits eight-word bursts and then the remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle, request will be taken |
| req_addr | input | ADDR_W | Start byte address (bits [1:0] ignored) |
| req_count | input | CNT_W | Number of words to load |
| req_err | output | 1 | One-cycle pulse for a refused count |
| txn_valid | output | 1 | Transaction presented |
| txn_ready | input | 1 | Consumer accepts the transaction |
| txn_addr | output | ADDR_W | Word-aligned start byte address of the transaction |
| txn_len | output | LEN_W | Transaction length in words (1 to 8) |
| txn_single | output | 1 | 1 for a single-word load, 0 for a burst |
| txn_last | output | 1 | Final transaction of the request |

## Verification
The bench sweeps every start word position, with both clean and dirty low address bits, against every count from 0 to 17, in two address regions. The corners are a start in the last word of a region, where a design that always bursts would send a one-word burst or cross into the next line, and an aligned start, where an off-by-one in the room calculation would emit a zero-length first piece. Counts of 10 and 11 at late offsets, which need a three-piece split, catch a design that drops the middle full burst and so loses words. Counts of 0 and 17 catch a design that issues transactions for a refused request. Stalls and stray requests during issue catch a design that changes a held transaction or takes a request while busy.

// File: rtl/lm_split_pkg.sv
package lm_split_pkg;

    // Control states of the splitter
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ISSUE  = 2'd1,
        S_REJECT = 2'd2
    } split_state_e;

endpackage

// File: rtl/lm_req_check.sv
// Decides whether a requested word count is legal.
module lm_req_check #(
    parameter int CNT_W     = 5,
    parameter int MAX_WORDS = 16
) (
    input  logic [CNT_W-1:0] count,
    output logic             count_ok
);
    always_comb begin
        count_ok = (count != '0) && (count <= CNT_W'(MAX_WORDS));
    end
endmodule

// File: rtl/lm_piece_calc.sv
// Works out the next piece from the current address and the words still owed.
module lm_piece_calc #(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int CNT_W      = 5,
    parameter int LEN_W      = 4,
    parameter int OFF_W      = 3
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  remaining,
    output logic [LEN_W-1:0]  piece_len,
    output logic              piece_single,
    output logic              piece_last,
    output logic [ADDR_W-1:0] next_addr,
    output logic [CNT_W-1:0]  next_remaining
);
    logic [OFF_W-1:0] word_idx;
    logic [LEN_W-1:0] room;

    always_comb begin
        word_idx = cur_addr[OFF_W+1:2];
        room     = LEN_W'(LINE_WORDS) - LEN_W'(word_idx);
        if (remaining < CNT_W'(room)) begin
            piece_len = LEN_W'(remaining);
        end else begin
            piece_len = room;
        end
        piece_single   = (piece_len == LEN_W'(1));
        next_addr      = cur_addr + (ADDR_W'(piece_len) << 2);
        next_remaining = remaining - CNT_W'(piece_len);
        piece_last     = (next_remaining == '0);
    end
endmodule

// File: rtl/lm_burst_splitter.sv
module lm_burst_splitter
    import lm_split_pkg::*;
#(
    parameter int  ADDR_W     = 32,
    parameter int  LINE_WORDS = 8,
    parameter int  MAX_WORDS  = 16,
    localparam int CNT_W      = $clog2(MAX_WORDS + 1),
    localparam int LEN_W      = $clog2(LINE_WORDS + 1),
    localparam int OFF_W      = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    output logic              req_err,
    output logic              txn_valid,
    input  logic              txn_ready,
    output logic [ADDR_W-1:0] txn_addr,
    output logic [LEN_W-1:0]  txn_len,
    output logic              txn_single,
    output logic              txn_last
);

    split_state_e      state_q, state_d;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [CNT_W-1:0]  remaining_q;
    logic              count_ok;
    logic [LEN_W-1:0]  piece_len;
    logic              piece_single;
    logic              piece_last;
    logic [ADDR_W-1:0] next_addr;
    logic [CNT_W-1:0]  next_remaining;
    logic              take_req;
    logic              take_txn;

    lm_req_check #(
        .CNT_W     (CNT_W),
        .MAX_WORDS (MAX_WORDS)
    ) u_req_check (
        .count    (req_count),
        .count_ok (count_ok)
    );

    lm_piece_calc #(
        .ADDR_W     (ADDR_W),
        .LINE_WORDS (LINE_WORDS),
        .CNT_W      (CNT_W),
        .LEN_W      (LEN_W),
        .OFF_W      (OFF_W)
    ) u_piece_calc (
        .cur_addr       (cur_addr_q),
        .remaining      (remaining_q),
        .piece_len      (piece_len),
        .piece_single   (piece_single),
        .piece_last     (piece_last),
        .next_addr      (next_addr),
        .next_remaining (next_remaining)
    );

    assign take_req = req_valid && (state_q == S_IDLE);
    assign take_txn = txn_ready && (state_q == S_ISSUE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    state_d = count_ok ? S_ISSUE : S_REJECT;
                end
            end
            S_ISSUE: begin
                if (txn_ready && piece_last) begin
                    state_d = S_IDLE;
                end
            end
            S_REJECT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Address and remaining-word registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q  <= '0;
            remaining_q <= '0;
        end else if (take_req) begin
            cur_addr_q  <= req_addr & ~ADDR_W'(3);
            remaining_q <= count_ok ? req_count : '0;
        end else if (take_txn) begin
            cur_addr_q  <= next_addr;
            remaining_q <= next_remaining;
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == S_IDLE);
        req_err    = (state_q == S_REJECT);
        txn_valid  = (state_q == S_ISSUE);
        txn_addr   = cur_addr_q;
        txn_len    = piece_len;
        txn_single = piece_single;
        txn_last   = piece_last;
    end

    // R8
    txn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) && $stable(txn_len)
                                       && $stable(txn_last) && $stable(txn_single)));

    // R4
    no_line_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (int'(txn_addr[OFF_W+1:2]) + int'(txn_len) <= LINE_WORDS));

    // R5
    later_piece_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready && !txn_last) |=> (txn_valid && txn_addr[OFF_W+1:0] == '0));

    // R7
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_len != '0 && txn_len <= LEN_W'(LINE_WORDS)));

    // R1
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!txn_valid && !req_err));

    // R10
    reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> (!req_err && req_ready && !txn_valid));

    // R9
    last_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready && txn_last) |=> req_ready);

endmodule

// File: tb/lm_burst_splitter_bench.sv
module lm_burst_splitter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic [4:0]  req_count;
    logic        req_err;
    logic        txn_valid;
    logic        txn_ready;
    logic [31:0] txn_addr;
    logic [3:0]  txn_len;
    logic        txn_single;
    logic        txn_last;

    int checks   = 0;
    int errors   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lm_burst_splitter u_lm_burst_splitter (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_count  (req_count),
        .req_err    (req_err),
        .txn_valid  (txn_valid),
        .txn_ready  (txn_ready),
        .txn_addr   (txn_addr),
        .txn_len    (txn_len),
        .txn_single (txn_single),
        .txn_last   (txn_last)
    );

    task automatic check_eq(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_req(logic [31:0] addr, int count, int seed);
        logic [31:0] a;
        int          rem;
        int          k;
        int          total;
        @(negedge clk);
        check_eq("R1", "req_ready before request", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_addr  = addr;
        req_count = 5'(count);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (count == 0 || count > 16) begin
            check_eq("R10", "req_err after bad count", {31'b0, req_err}, 32'd1);
            check_eq("R10", "txn_valid after bad count", {31'b0, txn_valid}, 32'd0);
            @(negedge clk);
            check_eq("R10", "req_err second cycle", {31'b0, req_err}, 32'd0);
            check_eq("R10", "txn_valid second cycle", {31'b0, txn_valid}, 32'd0);
            check_eq("R10", "idle after reject", {31'b0, req_ready}, 32'd1);
        end else begin
            a     = addr & ~32'd3;
            rem   = count;
            k     = 0;
            total = 0;
            while (rem > 0) begin
                int  idx;
                int  len;
                bit  last;
                string atag;
                idx  = int'((a >> 2) & 32'd7);
                len  = (rem < 8 - idx) ? rem : 8 - idx;
                last = (rem == len);
                if (k != 0) atag = "R5";
                else if ((addr & 32'h1F) == 0) atag = "R11";
                else if ((addr & 32'h3) != 0) atag = "R2";
                else atag = "R3";
                check_eq("R8", "txn_valid", {31'b0, txn_valid}, 32'd1);
                check_eq("R1", "req_ready while busy", {31'b0, req_ready}, 32'd0);
                check_eq(atag, "txn_addr", txn_addr, a);
                check_eq(last ? "R6" : atag, "txn_len", {28'b0, txn_len}, 32'(len));
                check_eq("R7", "txn_single", {31'b0, txn_single}, {31'b0, (len == 1)});
                check_eq("R9", "txn_last", {31'b0, txn_last}, {31'b0, last});
                check_eq("R4", "no boundary cross", {31'b0, (idx + int'(txn_len) <= 8)}, 32'd1);
                if (((k + seed) % 2) == 1) begin
                    txn_ready = 1'b0;
                    req_valid = 1'b1;
                    req_addr  = ~addr;
                    req_count = 5'd3;
                    @(negedge clk);
                    req_valid = 1'b0;
                    check_eq("R8", "txn_valid held", {31'b0, txn_valid}, 32'd1);
                    check_eq("R8", "txn_addr held", txn_addr, a);
                    check_eq("R8", "txn_len held", {28'b0, txn_len}, 32'(len));
                end
                total += int'(txn_len);
                txn_ready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                txn_ready = 1'b0;
                a   = a + 32'(len * 4);
                rem = rem - len;
                k++;
                if (k > 20) break;
            end
            check_eq("R6", "sum of lengths", 32'(total), 32'(count));
            check_eq("R9", "idle after last", {31'b0, req_ready}, 32'd1);
            check_eq("R9", "no txn after last", {31'b0, txn_valid}, 32'd0);
        end
    endtask

    initial begin
        logic [31:0] bases [2];
        bases[0]  = 32'h0000_0100;
        bases[1]  = 32'h8765_4320;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        req_count = '0;
        txn_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "reset req_ready", {31'b0, req_ready}, 32'd1);
        check_eq("R1", "reset txn_valid", {31'b0, txn_valid}, 32'd0);
        check_eq("R1", "reset req_err", {31'b0, req_err}, 32'd0);
        rst_n = 1'b1;
        for (int b = 0; b < 2; b++) begin
            for (int w = 0; w < 8; w++) begin
                for (int lb = 0; lb < 2; lb++) begin
                    for (int c = 0; c <= 17; c++) begin
                        run_req(bases[b] + 32'(w * 4) + 32'(lb * 3), c, w + c + lb);
                    end
                end
            end
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule